// File: doc/BRIEF.md
# NAND Data-Stream Prefetch and Posting Engine

This block moves a linear stream of bytes between a NAND-style data port and a shared byte FIFO, with no address generation of its own. Software first opens the page on the device by other means, then links the engine to one of eight chip-selects, chooses a direction, and writes a byte count. In fetch mode the engine issues read accesses to the device while the FIFO has room and the host drains the FIFO. In posting mode the host fills the FIFO and the engine issues write accesses while the FIFO holds enough data. It stops when the byte count is used up.

Each device access is a single request. It carries only the chip-select number and a width flag, so external address lines stay untouched. An 8-bit device moves one byte per request and a 16-bit device moves two. Count and threshold are always in bytes. The FIFO fill level in fetch mode, or its free space in posting mode, is compared with a threshold. The result drives either an interrupt level or a DMA request that covers a programmable number of host bytes.

Top module: `nand_stream_engine`

## Requirements
- R1: After reset, `dev_req`, `irq`, `dma_req`, `host_rd_valid` and `host_wr_ready` are 0. The run bit, done flag and remaining count read 0, and the threshold reads 1.
- R2: Register map, selected by `cfg_addr`:
  - 0 = control: bit0 is the run bit.
  - 1 = setup: bit0 direction (0 fetch, 1 posting), bit1 16-bit device, bits4:2 chip-select, bit5 sync (0 interrupt, 1 DMA), bit6 enable.
  - 2 = threshold.
  - 3 = byte count. A write loads it; a read returns the remaining count.
  - 4 = DMA request size.
  - 5 = status: bit0 done.
  Writes to registers 1 to 4 while the run bit is set leave them unchanged.
- R3: In fetch mode the engine issues read requests (`dev_we`=0) only while the 64-byte FIFO has room for one access. The host receives the bytes in arrival order; for a 16-bit access the low byte comes first.
- R4: In posting mode the engine issues write requests (`dev_we`=1) only while the FIFO holds one access worth of data. Bytes are packed little-endian into `dev_wdata`.
- R5: Each acknowledged request lowers the remaining count by 1 (8-bit device) or 2 (16-bit device). No request is issued once the count is 0.
- R6: Every request presents the programmed chip-select on `dev_cs` for the whole transfer.
- R7: The run bit clears itself when the count reaches 0, and the done flag is set at the same time. Writing 1 to status bit0 clears done.
- R8: Threshold and DMA size writes are clamped into the range 1 to 64 (a value of 0 becomes 1, a value above 64 becomes 64).
- R9: With sync=0 and enable=1, `irq` is high exactly while the metric is at or above the threshold. The metric is the fill level in fetch mode and the free space in posting mode.
- R10: With sync=1 and enable=1, `dma_req` rises when the metric reaches the threshold. It stays high until the DMA-size number of host bytes have moved, then falls.
- R11: A raised `dev_req` holds its direction and write data stable until `dev_ack`.
- R12: `host_rd_valid` can be high only in fetch mode and `host_wr_ready` only in posting mode, and each only with enable=1.
- R13: Writing the run bit while enable=0 leaves the engine stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| host_wr_valid | input | 1 | Host byte offered to FIFO (posting) |
| host_wr_data | input | 8 | Host byte |
| host_wr_ready | output | 1 | FIFO accepts a host byte |
| host_rd_valid | output | 1 | FIFO byte available to host (fetch) |
| host_rd_data | output | 8 | Byte at FIFO head |
| host_rd_ready | input | 1 | Host takes the head byte |
| dev_req | output | 1 | Device access request |
| dev_we | output | 1 | 1 = write access |
| dev_wide | output | 1 | 1 = 16-bit access |
| dev_cs | output | 3 | Target chip-select |
| dev_wdata | output | 16 | Write data |
| dev_ack | input | 1 | Access completes this cycle |
| dev_rdata | input | 16 | Read data valid with `dev_ack` |
| irq | output | 1 | Threshold interrupt level |
| dma_req | output | 1 | DMA request level |

## Verification
On every cycle, assertions check the following:
- FIFO level bounds and underflow.
- That no request is issued with a zero count.
- Chip-select binding and request stability until acknowledge.
- The frozen setup while running.
- The threshold range.
- That a DMA request only falls after a host byte moves.

Only the bench scenarios can show the rest:
- Byte ordering and little-endian packing end to end.
- Flow control stalling at a full FIFO.
- The exact count of requests per transfer.
- Self-clearing of the run bit.
- Interrupt levels against thresholds in both directions.
- That a DMA burst covers exactly the programmed number of bytes.

// File: rtl/nse_pkg.sv
package nse_pkg;

   localparam int NSE_CS_W = 3;

   typedef enum logic {
      DIR_FETCH = 1'b0,
      DIR_POST  = 1'b1
   } nse_dir_e;

   // bit order matches the setup register layout
   typedef struct packed {
      logic          en;
      logic          sync_dma;
      logic [2:0]    cs;
      logic          wide;
      nse_dir_e      dir;
   } nse_cfg_t;

   localparam logic [2:0] RA_CTRL   = 3'd0;
   localparam logic [2:0] RA_SETUP  = 3'd1;
   localparam logic [2:0] RA_THRESH = 3'd2;
   localparam logic [2:0] RA_COUNT  = 3'd3;
   localparam logic [2:0] RA_DMASZ  = 3'd4;
   localparam logic [2:0] RA_STATUS = 3'd5;

endpackage

// File: rtl/nse_fifo.sv
module nse_fifo #(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [1:0]    push_n,
   input  logic [15:0]   push_data,
   input  logic [1:0]    pop_n,
   output logic [15:0]   peek,
   output logic [LW-1:0] level,
   output logic [LW-1:0] free
);

   if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
      $error("nse_fifo: DEPTH must be a power of two of at least 4");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] level_q;

   always_ff @(posedge clk) begin
      for (int l = 0; l < 2; l++) begin
         if (!clr && push_n > 2'(l)) mem[wr_ptr + AW'(l)] <= push_data[l*8 +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else if (clr) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else begin
         wr_ptr  <= wr_ptr + AW'(push_n);
         rd_ptr  <= rd_ptr + AW'(pop_n);
         level_q <= level_q + LW'(push_n) - LW'(pop_n);
      end
   end

   assign peek  = {mem[rd_ptr + AW'(1)], mem[rd_ptr]};
   assign level = level_q;
   assign free  = LW'(DEPTH) - level_q;

   a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LW'(DEPTH));
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> LW'(pop_n) <= level_q);

endmodule

// File: rtl/nse_regs.sv
module nse_regs
   import nse_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int CNT_W = 16,
   localparam int LW = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_addr,
   input  logic [CNT_W-1:0] cfg_wdata,
   output logic [CNT_W-1:0] cfg_rdata,
   input  logic [CNT_W-1:0] remaining,
   input  logic             seq_done,
   output nse_cfg_t         cfg,
   output logic [LW-1:0]    thresh,
   output logic [LW-1:0]    dma_size,
   output logic             cnt_ld,
   output logic [CNT_W-1:0] cnt_val,
   output logic             run,
   output logic             cfg_clr
);

   nse_cfg_t      cfg_q;
   logic [LW-1:0] thresh_q, dmasz_q;
   logic          run_q, done_q;
   logic          wr_ok;

   function automatic logic [LW-1:0] clamp_lvl(input logic [CNT_W-1:0] v);
      if (v == '0) return LW'(1);
      if (int'(v) > DEPTH) return LW'(DEPTH);
      return v[LW-1:0];
   endfunction

   assign wr_ok = cfg_we && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         thresh_q <= LW'(1);
         dmasz_q  <= LW'(1);
         run_q    <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         if (cfg_we && cfg_addr == RA_STATUS && cfg_wdata[0]) done_q <= 1'b0;
         if (seq_done) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
         end
         if (wr_ok && cfg_addr == RA_CTRL && cfg_wdata[0] && cfg_q.en) run_q <= 1'b1;
         if (wr_ok && cfg_addr == RA_SETUP)  cfg_q    <= nse_cfg_t'(cfg_wdata[6:0]);
         if (wr_ok && cfg_addr == RA_THRESH) thresh_q <= clamp_lvl(cfg_wdata);
         if (wr_ok && cfg_addr == RA_DMASZ)  dmasz_q  <= clamp_lvl(cfg_wdata);
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         RA_CTRL:   cfg_rdata = CNT_W'(run_q);
         RA_SETUP:  cfg_rdata = CNT_W'(cfg_q);
         RA_THRESH: cfg_rdata = CNT_W'(thresh_q);
         RA_COUNT:  cfg_rdata = remaining;
         RA_DMASZ:  cfg_rdata = CNT_W'(dmasz_q);
         RA_STATUS: cfg_rdata = CNT_W'(done_q);
         default:   cfg_rdata = '0;
      endcase
   end

   assign cfg      = cfg_q;
   assign thresh   = thresh_q;
   assign dma_size = dmasz_q;
   assign cnt_ld   = wr_ok && cfg_addr == RA_COUNT;
   assign cnt_val  = cfg_wdata;
   assign run      = run_q;
   assign cfg_clr  = wr_ok && cfg_addr == RA_SETUP;

   // R2: setup is frozen while the engine runs
   a_r2_setup_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> $stable(cfg_q) && $stable(thresh_q) && $stable(dmasz_q));
   a_r8_thresh_range: assert property (@(posedge clk) disable iff (!rst_n)
      thresh_q >= LW'(1) && thresh_q <= LW'(DEPTH) && dmasz_q >= LW'(1));
   a_r13_run_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> cfg_q.en);

endmodule

// File: rtl/nse_seq.sv
module nse_seq
   import nse_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int CNT_W   = 16,
   parameter bit WIDE_EN = 1'b1,
   localparam int LW = $clog2(DEPTH) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  nse_dir_e            dir,
   input  logic                wide_cfg,
   input  logic [NSE_CS_W-1:0] cs_cfg,
   input  logic                cnt_ld,
   input  logic [CNT_W-1:0]    cnt_val,
   input  logic [LW-1:0]       level,
   input  logic [LW-1:0]       free,
   input  logic [15:0]         peek,
   input  logic                dev_ack,
   input  logic [15:0]         dev_rdata,
   output logic                dev_req,
   output logic                dev_we,
   output logic                dev_wide,
   output logic [NSE_CS_W-1:0] dev_cs,
   output logic [15:0]         dev_wdata,
   output logic [1:0]          push_n,
   output logic [15:0]         push_data,
   output logic [1:0]          pop_n,
   output logic [CNT_W-1:0]    remaining,
   output logic                done
);

   logic                wide_sel;
   logic [1:0]          asz, asz_q;
   logic                req_q, we_q, wide_q;
   logic [NSE_CS_W-1:0] cs_q;
   logic [15:0]         wdata_q;
   logic [CNT_W-1:0]    rem_q;
   logic                avail, issue, complete;

   if (WIDE_EN) begin : g_wide
      assign wide_sel = wide_cfg;
   end else begin : g_narrow
      assign wide_sel = 1'b0;
   end

   assign asz      = wide_sel ? 2'd2 : 2'd1;
   assign asz_q    = wide_q ? 2'd2 : 2'd1;
   assign avail    = (dir == DIR_FETCH) ? (free >= LW'(asz)) : (level >= LW'(asz));
   assign issue    = run && !req_q && rem_q != '0 && avail;
   assign complete = req_q && dev_ack;
   assign done     = run && !req_q && rem_q == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         we_q    <= 1'b0;
         wide_q  <= 1'b0;
         cs_q    <= '0;
         wdata_q <= '0;
         rem_q   <= '0;
      end else begin
         if (issue) begin
            req_q   <= 1'b1;
            we_q    <= (dir == DIR_POST);
            wide_q  <= wide_sel;
            cs_q    <= cs_cfg;
            wdata_q <= wide_sel ? peek : {8'h00, peek[7:0]};
         end else if (complete) begin
            req_q <= 1'b0;
         end
         if (cnt_ld) rem_q <= cnt_val;
         else if (complete) rem_q <= (rem_q <= CNT_W'(asz_q)) ? '0 : rem_q - CNT_W'(asz_q);
      end
   end

   assign push_n    = (complete && !we_q) ? asz_q : 2'd0;
   assign pop_n     = (complete &&  we_q) ? asz_q : 2'd0;
   assign push_data = wide_q ? dev_rdata : {8'h00, dev_rdata[7:0]};

   assign dev_req   = req_q;
   assign dev_we    = we_q;
   assign dev_wide  = wide_q;
   assign dev_cs    = cs_q;
   assign dev_wdata = wdata_q;
   assign remaining = rem_q;

   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req && !dev_ack |=> dev_req && $stable(dev_we) && $stable(dev_wdata) && $stable(dev_cs));
   a_r5_no_req_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req |-> rem_q != '0);
   a_r6_cs_bound: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req |-> dev_cs == cs_cfg && run);
   a_r4_post_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req && dev_we |-> level >= LW'(asz_q));

endmodule

// File: rtl/nse_sync.sv
module nse_sync
   import nse_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int LW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          sync_dma,
   input  nse_dir_e      dir,
   input  logic [LW-1:0] thresh,
   input  logic [LW-1:0] dma_size,
   input  logic [LW-1:0] level,
   input  logic [LW-1:0] free,
   input  logic          host_xfer,
   output logic          irq,
   output logic          dma_req
);

   logic [LW-1:0] metric, budget_q;
   logic          hit, act_q;

   assign metric = (dir == DIR_FETCH) ? level : free;
   assign hit    = en && metric >= thresh;
   assign irq    = hit && !sync_dma;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         budget_q <= '0;
      end else if (!(en && sync_dma)) begin
         act_q <= 1'b0;
      end else if (!act_q) begin
         if (hit) begin
            act_q    <= 1'b1;
            budget_q <= dma_size;
         end
      end else if (host_xfer) begin
         if (budget_q <= LW'(1)) act_q <= 1'b0;
         budget_q <= budget_q - LW'(1);
      end
   end

   assign dma_req = act_q;

   a_r10_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !host_xfer && en && sync_dma |=> dma_req);
   a_r10_dma_fall_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_req) && en && sync_dma && $past(en && sync_dma) |-> $past(host_xfer));

endmodule

// File: rtl/nand_stream_engine.sv
module nand_stream_engine
   import nse_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int CNT_W   = 16,
   parameter bit WIDE_EN = 1'b1,
   localparam int LW = $clog2(DEPTH) + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [2:0]          cfg_addr,
   input  logic [CNT_W-1:0]    cfg_wdata,
   output logic [CNT_W-1:0]    cfg_rdata,
   input  logic                host_wr_valid,
   input  logic [7:0]          host_wr_data,
   output logic                host_wr_ready,
   output logic                host_rd_valid,
   output logic [7:0]          host_rd_data,
   input  logic                host_rd_ready,
   output logic                dev_req,
   output logic                dev_we,
   output logic                dev_wide,
   output logic [NSE_CS_W-1:0] dev_cs,
   output logic [15:0]         dev_wdata,
   input  logic                dev_ack,
   input  logic [15:0]         dev_rdata,
   output logic                irq,
   output logic                dma_req
);

   if (CNT_W < LW || CNT_W < 7) begin : g_bad_cnt
      $error("nand_stream_engine: CNT_W too narrow for register fields");
   end

   nse_cfg_t         cfg;
   logic [LW-1:0]    thresh, dma_size, level, free;
   logic             cnt_ld, run, cfg_clr, seq_done;
   logic [CNT_W-1:0] cnt_val, remaining;
   logic [1:0]       seq_push_n, seq_pop_n, f_push_n, f_pop_n;
   logic [15:0]      seq_push_data, f_push_data, peek;
   logic             rd_hs, wr_hs;

   nse_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) regs_i (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
      .remaining, .seq_done, .cfg, .thresh, .dma_size,
      .cnt_ld, .cnt_val, .run, .cfg_clr
   );

   nse_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .WIDE_EN(WIDE_EN)) seq_i (
      .clk, .rst_n, .run, .dir(cfg.dir), .wide_cfg(cfg.wide), .cs_cfg(cfg.cs),
      .cnt_ld, .cnt_val, .level, .free, .peek, .dev_ack, .dev_rdata,
      .dev_req, .dev_we, .dev_wide, .dev_cs, .dev_wdata,
      .push_n(seq_push_n), .push_data(seq_push_data), .pop_n(seq_pop_n),
      .remaining, .done(seq_done)
   );

   assign host_rd_valid = cfg.en && cfg.dir == DIR_FETCH && level != '0;
   assign host_wr_ready = cfg.en && cfg.dir == DIR_POST && free != '0;
   assign host_rd_data  = peek[7:0];
   assign rd_hs         = host_rd_valid && host_rd_ready;
   assign wr_hs         = host_wr_valid && host_wr_ready;

   always_comb begin
      if (cfg.dir == DIR_FETCH) begin
         f_push_n    = seq_push_n;
         f_push_data = seq_push_data;
         f_pop_n     = {1'b0, rd_hs};
      end else begin
         f_push_n    = {1'b0, wr_hs};
         f_push_data = {8'h00, host_wr_data};
         f_pop_n     = seq_pop_n;
      end
   end

   nse_fifo #(.DEPTH(DEPTH)) fifo_i (
      .clk, .rst_n, .clr(cfg_clr), .push_n(f_push_n), .push_data(f_push_data),
      .pop_n(f_pop_n), .peek, .level, .free
   );

   nse_sync #(.DEPTH(DEPTH)) sync_i (
      .clk, .rst_n, .en(cfg.en), .sync_dma(cfg.sync_dma), .dir(cfg.dir),
      .thresh, .dma_size, .level, .free, .host_xfer(rd_hs || wr_hs),
      .irq, .dma_req
   );

   a_r12_host_side_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rd_valid && host_wr_ready));

endmodule

// File: tb/nand_stream_engine_tb_top.sv
module nand_stream_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        host_wr_valid = 1'b0;
   logic [7:0]  host_wr_data = '0;
   logic        host_wr_ready;
   logic        host_rd_valid;
   logic [7:0]  host_rd_data;
   logic        host_rd_ready = 1'b0;
   logic        dev_req, dev_we, dev_wide;
   logic [2:0]  dev_cs;
   logic [15:0] dev_wdata;
   logic        dev_ack = 1'b0;
   logic [15:0] dev_rdata = '0;
   logic        irq, dma_req;

   always #2 clk = ~clk;

   nand_stream_engine dut_i (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
      .host_wr_valid, .host_wr_data, .host_wr_ready,
      .host_rd_valid, .host_rd_data, .host_rd_ready,
      .dev_req, .dev_we, .dev_wide, .dev_cs, .dev_wdata,
      .dev_ack, .dev_rdata, .irq, .dma_req
   );

   int n_chk = 0, n_err = 0;
   logic [7:0] exp_q [$];
   logic [7:0] pat = 8'h10;
   int  req_cnt = 0;
   int  dma_bytes = 0, dma_falls = 0;
   logic [2:0] exp_cs = '0;
   bit  rd_go = 0, rd_gate_dma = 0, dma_chk = 0, timeout = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic host_write(input logic [7:0] b);
      do @(negedge clk); while (!host_wr_ready);
      host_wr_valid = 1'b1; host_wr_data = b;
      exp_q.push_back(b);
      @(negedge clk);
      host_wr_valid = 1'b0;
   endtask

   task automatic wait_stop();
      logic [15:0] v;
      for (int i = 0; i < 4000; i++) begin
         cfg_rd(3'd0, v);
         if (!v[0]) break;
      end
   endtask

   // device model: serves requests, produces/consumes scoreboard bytes
   initial begin
      forever begin
         @(negedge clk);
         dev_ack = 1'b0;
         if (dev_req) begin
            if (req_cnt % 3 == 2) repeat (2) @(negedge clk);
            chk(dev_cs == exp_cs, "R6 chip-select", dev_cs, exp_cs);
            if (!dev_we) begin
               if (dev_wide) begin
                  dev_rdata = {pat + 8'd1, pat};
                  exp_q.push_back(pat);
                  exp_q.push_back(pat + 8'd1);
                  pat = pat + 8'd2;
               end else begin
                  dev_rdata = {8'hEE, pat};
                  exp_q.push_back(pat);
                  pat = pat + 8'd1;
               end
            end else begin
               logic [15:0] e;
               e = '0;
               if (exp_q.size() > 0) e[7:0] = exp_q.pop_front();
               if (dev_wide && exp_q.size() > 0) e[15:8] = exp_q.pop_front();
               chk(dev_wdata == e, "R4 posted data", dev_wdata, e);
            end
            dev_ack = 1'b1;
            req_cnt++;
         end
      end
   end

   // host read monitor: compares FIFO output with the scoreboard
   initial begin
      bit prev_dma;
      prev_dma = 0;
      forever begin
         @(negedge clk);
         host_rd_ready = 1'b0;
         if (dma_chk && prev_dma && !dma_req) begin
            chk(dma_bytes == 16, "R10 dma burst size", dma_bytes, 16);
            dma_falls++;
            dma_bytes = 0;
         end
         if (!dma_chk) dma_bytes = 0;
         prev_dma = dma_req;
         if (rd_go && host_rd_valid && (!rd_gate_dma || dma_req)) begin
            logic [7:0] e;
            host_rd_ready = 1'b1;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hXX;
            chk(host_rd_data == e, "R3 fetch order", host_rd_data, e);
            if (dma_req) dma_bytes++;
         end
      end
   end

   task automatic run_all();
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!dev_req && !irq && !dma_req, "R1 outputs idle", {dev_req, irq, dma_req}, 0);
      chk(!host_rd_valid && !host_wr_ready, "R1 host side idle", {host_rd_valid, host_wr_ready}, 0);
      cfg_rd(3'd0, v); chk(v == 0, "R1 run bit", v, 0);
      cfg_rd(3'd5, v); chk(v == 0, "R1 done", v, 0);
      cfg_rd(3'd3, v); chk(v == 0, "R1 remaining", v, 0);
      cfg_rd(3'd2, v); chk(v == 1, "R1 threshold", v, 1);

      // R8 clamping
      cfg_wr(3'd2, 16'd0);   cfg_rd(3'd2, v); chk(v == 1,  "R8 clamp low", v, 1);
      cfg_wr(3'd2, 16'd200); cfg_rd(3'd2, v); chk(v == 64, "R8 clamp high", v, 64);
      cfg_wr(3'd2, 16'd17);  cfg_rd(3'd2, v); chk(v == 17, "R8 in range", v, 17);
      cfg_wr(3'd4, 16'd0);   cfg_rd(3'd4, v); chk(v == 1,  "R8 dma size low", v, 1);

      // R13 start with enable clear
      cfg_wr(3'd1, 16'd0);
      cfg_wr(3'd3, 16'd4);
      cfg_wr(3'd0, 16'd1);
      cfg_rd(3'd0, v); chk(v == 0, "R13 run ignored", v, 0);
      chk(!host_rd_valid && !host_wr_ready, "R12 disabled host side", {host_rd_valid, host_wr_ready}, 0);

      // fetch, 8-bit device, cs 5, irq sync
      exp_cs = 3'd5; req_cnt = 0;
      cfg_wr(3'd1, 16'd84);
      cfg_wr(3'd2, 16'd8);
      cfg_wr(3'd3, 16'd20);
      cfg_wr(3'd0, 16'd1);
      cfg_rd(3'd0, v); chk(v == 1, "R7 run set", v, 1);
      cfg_wr(3'd1, 16'd75);
      cfg_wr(3'd3, 16'd99);
      cfg_wr(3'd2, 16'd3);
      cfg_rd(3'd1, v); chk(v == 84, "R2 setup frozen", v, 84);
      cfg_rd(3'd2, v); chk(v == 8,  "R2 threshold frozen", v, 8);
      wait_stop();
      cfg_rd(3'd3, v); chk(v == 0, "R5 remaining zero", v, 0);
      chk(req_cnt == 20, "R5 byte requests", req_cnt, 20);
      cfg_rd(3'd5, v); chk(v == 1, "R7 done set", v, 1);
      chk(irq == 1'b1, "R9 irq at level 20", irq, 1);
      chk(!host_wr_ready, "R12 no host write in fetch", host_wr_ready, 0);
      rd_go = 1;
      for (int i = 0; i < 200 && (exp_q.size() > 0 || host_rd_valid); i++) @(negedge clk);
      rd_go = 0;
      chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
      @(negedge clk);
      chk(irq == 1'b0, "R9 irq drops when empty", irq, 0);
      cfg_wr(3'd5, 16'd1);
      cfg_rd(3'd5, v); chk(v == 0, "R7 done cleared", v, 0);

      // fetch, 16-bit device, cs 1, dma sync, flow control at full FIFO
      exp_cs = 3'd1; req_cnt = 0;
      cfg_wr(3'd1, 16'd102);
      cfg_wr(3'd2, 16'd32);
      cfg_wr(3'd4, 16'd16);
      cfg_wr(3'd3, 16'd80);
      dma_chk = 1; rd_gate_dma = 1;
      cfg_wr(3'd0, 16'd1);
      repeat (300) @(negedge clk);
      chk(req_cnt == 32, "R3 stalls at full FIFO", req_cnt, 32);
      cfg_rd(3'd3, v); chk(v == 16, "R5 remaining after 32 words", v, 16);
      chk(dma_req == 1'b1, "R10 dma raised", dma_req, 1);
      chk(irq == 1'b0, "R9 irq off in dma sync", irq, 0);
      rd_go = 1;
      wait_stop();
      repeat (100) @(negedge clk);
      chk(req_cnt == 40, "R5 word requests", req_cnt, 40);
      chk(dma_falls >= 2, "R10 bursts completed", dma_falls, 2);
      dma_chk = 0; rd_gate_dma = 0;
      for (int i = 0; i < 300 && (exp_q.size() > 0 || host_rd_valid); i++) @(negedge clk);
      rd_go = 0;
      chk(exp_q.size() == 0, "R3 wide bytes delivered", exp_q.size(), 0);
      cfg_wr(3'd5, 16'd1);

      // posting, 16-bit device, cs 2, irq on free space
      exp_cs = 3'd2; req_cnt = 0;
      cfg_wr(3'd1, 16'd75);
      cfg_wr(3'd2, 16'd60);
      cfg_wr(3'd3, 16'd40);
      @(negedge clk);
      chk(irq == 1'b1, "R9 irq on free space", irq, 1);
      chk(!host_rd_valid, "R12 no host read in posting", host_rd_valid, 0);
      cfg_wr(3'd0, 16'd1);
      for (int i = 0; i < 40; i++) host_write(8'hA0 + 8'(i));
      wait_stop();
      chk(req_cnt == 20, "R5 posted word count", req_cnt, 20);
      chk(exp_q.size() == 0, "R4 all bytes posted", exp_q.size(), 0);
      cfg_rd(3'd5, v); chk(v == 1, "R7 done after posting", v, 1);
      cfg_wr(3'd5, 16'd1);

      // posting, 8-bit device, cs 7
      exp_cs = 3'd7; req_cnt = 0;
      cfg_wr(3'd1, 16'd93);
      cfg_wr(3'd3, 16'd3);
      cfg_wr(3'd0, 16'd1);
      host_write(8'h5A); host_write(8'hC3); host_write(8'h01);
      wait_stop();
      chk(req_cnt == 3, "R5 posted byte count", req_cnt, 3);
      chk(!dev_req, "R5 no request at zero", dev_req, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timeout = 1;
         end
      join_any
      if (timeout) chk(1'b0, "watchdog", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule